// File: doc/BRIEF.md
# Overlapped Block Input Load Controller

This block runs the input side of a block transform engine in the operating mode where successive transforms overlap. It counts strobed input samples into a buffer address space and drives a write address and write enable toward the buffer RAM. When the selected mode is active it starts a load phase. In that phase it holds a visible load flag high until one normal block has been written. It then keeps writing the extra samples that later overlapped transforms will need, so that those transforms never wait for fresh input.

Loading, transforming and dumping never overlap in time. After the last extra sample is written, the block gives the engine a one-cycle start pulse. It then ignores the strobe until the engine reports that all overlapped transforms are finished. After that report it samples the configuration again and begins a new load at address zero. The largest transform size leaves no room in the buffer for extra samples. That size combined with any overlap, or a reserved overlap code, puts the block into a sticky configuration fault.

Top module: `ovl_load_ctrl`

## Requirements
- R1: While reset is asserted, and at the first clock after it, the outputs wr_en, load_busy, xf_start and cfg_err are all 0.
- R2: While mode_sel is not 2'b11, the block stays idle: strobes cause no write and load_busy stays 0.
- R3: In a load phase, each cycle in which smp_stb is high writes one sample. wr_en is high in that same cycle, and wr_addr counts 0, 1, 2 … with no gaps. A strobe may arrive on every clock, and cycles without a strobe write nothing.
- R4: The normal block length N depends on size_sel. Codes 0, 1 and 2 give 2^MIN_LOG2, twice that and four times that. Code 3 gives 2^MAX_LOG2. The load length is N plus an extra part set by ovl_sel: code 0 (no overlap) adds 0, code 1 (half overlap) adds N/2, and code 2 (quarter hop) adds N/4.
- R5: load_busy is high from the start of a load until the write of sample N-1, and it reads 0 from the next cycle on. Writes of the extra samples continue after the flag has dropped.
- R6: xf_start is high for exactly one cycle, in the cycle after the final write of the load.
- R7: From the final write until xf_done is seen, strobes are ignored and wr_en stays 0.
- R8: After xf_done is seen, the block takes one idle cycle, samples the configuration, and starts a new load at address 0 with load_busy high.
- R9: size_sel = 3 together with a nonzero ovl_sel, sampled at load start, sets cfg_err. Once set, cfg_err stays set until reset, with no further writes, load_busy or xf_start.
- R10: ovl_sel = 3 is reserved. It sets cfg_err in the same way, and a valid configuration after reset loads normally.
- R11: The configuration is sampled only at the start of a load. Changes to size_sel or ovl_sel during a load do not alter the length of that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Operating-mode bits; 2'b11 enables overlapped loading |
| size_sel | input | 2 | Transform size code |
| ovl_sel | input | 2 | Overlap code (0 none, 1 half, 2 quarter hop, 3 reserved) |
| smp_stb | input | 1 | Sample strobe, synchronous to clk |
| xf_done | input | 1 | Engine reports all overlapped transforms finished |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | MAX_LOG2 | Buffer write address |
| load_busy | output | 1 | Visible load flag, high until a normal block is in |
| xf_start | output | 1 | One-cycle transform start pulse |
| cfg_err | output | 1 | Sticky configuration fault |

## Verification
The bench sweeps every legal size and overlap combination, with back-to-back strobes and with irregular gaps, and compares each write address and the flag state against lengths it computes itself. A design that dropped load_busy at the total length rather than at N, or that used the wrong extra fraction, would show the flag or the start pulse one or more samples away from the expected point. Strobes are driven during the start cycle and during the wait for completion, so a controller that kept writing or restarted early would raise wr_en there. The configuration is scrambled partway through each load, the fault combinations are driven both before and after reset, and any leak of live configuration or any loss of the sticky fault therefore shows up as a wrong length or a cleared cfg_err.

// File: rtl/ovl_load_pkg.sv
package ovl_load_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_KICK  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_FAULT = 3'd4
    } ld_state_e;

    localparam logic [1:0] MODE_OVL_LOAD = 2'b11;

    localparam logic [1:0] OVL_NONE    = 2'd0;
    localparam logic [1:0] OVL_HALF    = 2'd1;
    localparam logic [1:0] OVL_QUARTER = 2'd2;
    localparam logic [1:0] OVL_RSVD    = 2'd3;

    localparam logic [1:0] SIZE_TOP = 2'd3;

endpackage

// File: rtl/ovl_len_calc.sv
module ovl_len_calc
    import ovl_load_pkg::*;
#(
    parameter int MIN_LOG2 = 6,
    parameter int MAX_LOG2 = 10,
    parameter int LEN_W    = MAX_LOG2 + 1
) (
    input  logic [1:0]       size_sel,
    input  logic [1:0]       ovl_sel,
    output logic [LEN_W-1:0] norm_len,
    output logic [LEN_W-1:0] total_len,
    output logic             bad_cfg
);

    logic [LEN_W-1:0] extra_len;

    // normal block length from the size code
    always_comb begin
        if (size_sel == SIZE_TOP) begin
            norm_len = LEN_W'(1) << MAX_LOG2;
        end else begin
            norm_len = LEN_W'(1) << (MIN_LOG2 + int'(size_sel));
        end
    end

    // extra samples kept for the overlapped transforms
    always_comb begin
        case (ovl_sel)
            OVL_HALF:    extra_len = norm_len >> 1;
            OVL_QUARTER: extra_len = norm_len >> 2;
            default:     extra_len = '0;
        endcase
    end

    assign total_len = norm_len + extra_len;

    // the top size has no room for extra samples; code 3 is reserved
    assign bad_cfg = (ovl_sel == OVL_RSVD) ||
                     ((size_sel == SIZE_TOP) && (ovl_sel != OVL_NONE));

endmodule

// File: rtl/ovl_sample_counter.sv
module ovl_sample_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/ovl_load_ctrl.sv
module ovl_load_ctrl
    import ovl_load_pkg::*;
#(
    parameter int MIN_LOG2 = 6,
    parameter int MAX_LOG2 = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_sel,
    input  logic [1:0]          size_sel,
    input  logic [1:0]          ovl_sel,
    input  logic                smp_stb,
    input  logic                xf_done,
    output logic                wr_en,
    output logic [MAX_LOG2-1:0] wr_addr,
    output logic                load_busy,
    output logic                xf_start,
    output logic                cfg_err
);

    localparam int ADDR_W = MAX_LOG2;
    localparam int LEN_W  = MAX_LOG2 + 1;

    typedef struct packed {
        ld_state_e        state;
        logic [LEN_W-1:0] norm_len;
        logic [LEN_W-1:0] total_len;
        logic             cfg_err;
    } ctrl_t;

    ctrl_t cur_q;
    ctrl_t nxt_d;

    logic [LEN_W-1:0] calc_norm;
    logic [LEN_W-1:0] calc_total;
    logic             calc_bad;
    logic [LEN_W-1:0] cnt;
    logic             cnt_clr;
    logic             wr_en_c;
    logic             last_smp;

    ovl_len_calc #(
        .MIN_LOG2(MIN_LOG2),
        .MAX_LOG2(MAX_LOG2),
        .LEN_W   (LEN_W)
    ) u_len (
        .size_sel (size_sel),
        .ovl_sel  (ovl_sel),
        .norm_len (calc_norm),
        .total_len(calc_total),
        .bad_cfg  (calc_bad)
    );

    ovl_sample_counter #(
        .CNT_W(LEN_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (wr_en_c),
        .cnt  (cnt)
    );

    assign last_smp = (cnt == (cur_q.total_len - LEN_W'(1)));

    always_comb begin
        nxt_d   = cur_q;
        cnt_clr = 1'b0;
        wr_en_c = 1'b0;
        case (cur_q.state)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (mode_sel == MODE_OVL_LOAD) begin
                    if (calc_bad) begin
                        nxt_d.state   = ST_FAULT;
                        nxt_d.cfg_err = 1'b1;
                    end else begin
                        nxt_d.state     = ST_LOAD;
                        nxt_d.norm_len  = calc_norm;
                        nxt_d.total_len = calc_total;
                    end
                end
            end
            ST_LOAD: begin
                if (smp_stb) begin
                    wr_en_c = 1'b1;
                    if (last_smp) begin
                        nxt_d.state = ST_KICK;
                    end
                end
            end
            ST_KICK: begin
                nxt_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (xf_done) begin
                    nxt_d.state = ST_IDLE;
                end
            end
            ST_FAULT: begin
                nxt_d.cfg_err = 1'b1;
            end
            default: begin
                nxt_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state     <= ST_IDLE;
            cur_q.norm_len  <= '0;
            cur_q.total_len <= '0;
            cur_q.cfg_err   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign wr_en     = wr_en_c;
    assign wr_addr   = cnt[ADDR_W-1:0];
    assign load_busy = (cur_q.state == ST_LOAD) && (cnt < cur_q.norm_len);
    assign xf_start  = (cur_q.state == ST_KICK);
    assign cfg_err   = cur_q.cfg_err;

endmodule

// File: rtl/ovl_load_ctrl_chk.sv
module ovl_load_ctrl_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_stb,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              load_busy,
    input logic              xf_start,
    input logic              cfg_err
);

    p_wr_needs_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> smp_stb);

    p_addr_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!wr_en || (wr_addr == $past(wr_addr) + ADDR_W'(1))));

    p_flag_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_busy) |-> $past(wr_en));

    p_flag_low_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xf_start |-> !load_busy);

    p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xf_start |=> !xf_start);

    p_start_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xf_start |-> $past(wr_en));

    p_no_write_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xf_start |-> !wr_en);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!wr_en && !load_busy && !xf_start));

endmodule

bind ovl_load_ctrl ovl_load_ctrl_chk #(
    .ADDR_W(MAX_LOG2)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .load_busy(load_busy),
    .xf_start (xf_start),
    .cfg_err  (cfg_err)
);

// File: tb/ovl_load_ctrl_bench.sv
`timescale 1ns/1ps
module ovl_load_ctrl_bench;

    localparam int MIN_L = 2;
    localparam int MAX_L = 5;
    localparam int AW    = MAX_L;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode_sel;
    logic [1:0]    size_sel;
    logic [1:0]    ovl_sel;
    logic          smp_stb;
    logic          xf_done;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          load_busy;
    logic          xf_start;
    logic          cfg_err;

    int errs   = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    ovl_load_ctrl #(
        .MIN_LOG2(MIN_L),
        .MAX_LOG2(MAX_L)
    ) u_ovl_load_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .size_sel (size_sel),
        .ovl_sel  (ovl_sel),
        .smp_stb  (smp_stb),
        .xf_done  (xf_done),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .load_busy(load_busy),
        .xf_start (xf_start),
        .cfg_err  (cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int norm_of(input int sz);
        return (sz == 3) ? (1 << MAX_L) : (1 << (MIN_L + sz));
    endfunction

    function automatic int total_of(input int sz, input int ov);
        int n;
        n = norm_of(sz);
        if (ov == 1) return n + n / 2;
        if (ov == 2) return n + n / 4;
        return n;
    endfunction

    task automatic pulse_done();
        @(negedge clk);
        xf_done = 1'b1;
        @(negedge clk);
        xf_done = 1'b0;
    endtask

    task automatic stream(input int sz, input int ov, input bit gappy);
        int n;
        int t;
        n = norm_of(sz);
        t = total_of(sz, ov);
        for (int k = 0; k < t; k++) begin
            int g;
            g = gappy ? (k % 3) : 0;
            for (int j = 0; j < g; j++) begin
                @(negedge clk);
                smp_stb = 1'b0;
                #1;
                chk(!wr_en, "R3 no write without strobe", int'(wr_en), 0);
                chk(load_busy == (k < n), "R5 flag during gap", int'(load_busy), int'(k < n));
            end
            @(negedge clk);
            smp_stb = 1'b1;
            if (k == 1) begin
                size_sel = 2'(3 - sz);
                ovl_sel  = 2'((ov + 1) % 3);
            end
            #1;
            chk(wr_en && (int'(wr_addr) == k), "R3 write address", int'(wr_addr), k);
            chk(load_busy == (k < n), "R5 load flag", int'(load_busy), int'(k < n));
        end
        @(negedge clk);
        smp_stb = 1'b1;
        #1;
        chk(xf_start == 1'b1, "R11 latched length gives start here", int'(xf_start), 1);
        chk(xf_start == 1'b1, "R6 start after last write", int'(xf_start), 1);
        chk(!wr_en, "R7 strobe ignored at start", int'(wr_en), 0);
        chk(!load_busy, "R5 flag low at start", int'(load_busy), 0);
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            #1;
            chk(!xf_start, "R6 start single cycle", int'(xf_start), 0);
            chk(!wr_en, "R7 strobe ignored while waiting", int'(wr_en), 0);
        end
        smp_stb = 1'b0;
    endtask

    task automatic expect_load_start(input string req);
        @(negedge clk);
        #1;
        chk(load_busy == 1'b1, req, int'(load_busy), 1);
        chk(!cfg_err, req, int'(cfg_err), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int idx;
        rst_n    = 1'b0;
        mode_sel = 2'b00;
        size_sel = 2'd0;
        ovl_sel  = 2'd0;
        smp_stb  = 1'b0;
        xf_done  = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(!wr_en && !load_busy && !xf_start && !cfg_err, "R1 reset outputs",
            int'({wr_en, load_busy, xf_start, cfg_err}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!wr_en && !load_busy && !xf_start && !cfg_err, "R1 first cycle after reset",
            int'({wr_en, load_busy, xf_start, cfg_err}), 0);

        // mode bits not selecting overlapped loading
        for (int m = 0; m < 3; m++) begin
            @(negedge clk);
            mode_sel = 2'(m);
            smp_stb  = 1'b1;
            #1;
            chk(!wr_en, "R2 no write in other mode", int'(wr_en), 0);
            @(negedge clk);
            #1;
            chk(!load_busy, "R2 flag stays low in other mode", int'(load_busy), 0);
        end
        @(negedge clk);
        smp_stb  = 1'b0;
        size_sel = 2'd0;
        ovl_sel  = 2'd0;
        mode_sel = 2'b11;
        expect_load_start("R8 load begins when mode selected");

        idx = 0;
        for (int sz = 0; sz < 4; sz++) begin
            for (int ov = 0; ov < 3; ov++) begin
                if (sz == 3 && ov != 0) continue;
                if (idx != 0) begin
                    size_sel = 2'(sz);
                    ovl_sel  = 2'(ov);
                    pulse_done();
                    expect_load_start("R8 new load after done");
                end
                stream(sz, ov, idx[0]);
                idx++;
            end
        end

        // R4 total length for the top size with no overlap covered above; now faults
        size_sel = 2'd3;
        ovl_sel  = 2'd1;
        pulse_done();
        @(negedge clk);
        #1;
        chk(cfg_err == 1'b1, "R9 top size with overlap faults", int'(cfg_err), 1);
        chk(!load_busy, "R9 no load on fault", int'(load_busy), 0);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            smp_stb = 1'b1;
            #1;
            chk(!wr_en, "R9 strobe ignored on fault", int'(wr_en), 0);
        end
        smp_stb  = 1'b0;
        size_sel = 2'd0;
        ovl_sel  = 2'd0;
        pulse_done();
        @(negedge clk);
        #1;
        chk(cfg_err == 1'b1, "R9 fault sticky", int'(cfg_err), 1);
        chk(!load_busy, "R9 still no load", int'(load_busy), 0);

        // reset clears, reserved overlap code faults
        @(negedge clk);
        rst_n   = 1'b0;
        ovl_sel = 2'd3;
        #1;
        chk(!cfg_err && !load_busy, "R1 reset clears fault", int'({cfg_err, load_busy}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(cfg_err == 1'b1, "R10 reserved overlap faults", int'(cfg_err), 1);

        @(negedge clk);
        rst_n   = 1'b0;
        ovl_sel = 2'd2;
        size_sel = 2'd1;
        @(negedge clk);
        rst_n = 1'b1;
        expect_load_start("R10 valid config after reset loads");
        stream(1, 2, 1'b1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule